// File: doc/BRIEF.md
# Switchable-Width Static RAM Core

This block is a synthesizable stand-in for a static RAM whose data organization is picked by a mode input. With the mode input high, the array is a column of 16-bit words. Each word has a low byte lane and a high byte lane, and each lane has its own enable. With the mode input low, the same storage is seen as twice as many 8-bit bytes. An extra address input then acts as the least significant byte-address bit. The storage depth is a parameter, so that simulation stays small.

An access is qualified by two chip enables of opposite polarity (one active low, one active high), an active-low output enable and an active-low write enable. The data bus is split into a write-data input and a read-data output. A two-bit lane-drive output takes the place of tristate drivers: a high bit means that lane is being driven. A lane that is not driven reads as zero.

Writes are captured on the rising clock edge while the write condition holds. Read data follows the address and controls combinationally. Contents are undefined until written. Byte address 2k lands in the low half of word k, and byte address 2k+1 lands in the high half.

Top module: `swsram_core`

## Requirements
- R1: The device is selected only when `cs1_n` is 0 and `cs2` is 1. Otherwise `rd_drive` is 2'b00 and no storage location changes.
- R2: In word mode (`wide` = 1), with both `lane_lo_n` and `lane_hi_n` at 1, the device behaves as deselected: nothing is driven and nothing is written.
- R3: In word mode, a read (selected, `wr_n` = 1, `rd_n` = 0) drives word `addr`. The low byte appears on `rd_data[7:0]` with `rd_drive[0]` set when `lane_lo_n` = 0. The high byte appears on `rd_data[15:8]` with `rd_drive[1]` set when `lane_hi_n` = 0.
- R4: In word mode, a selected write (`wr_n` = 0) updates at the next rising clock edge only the lanes whose enable is 0. `wr_data[7:0]` goes to the low lane and `wr_data[15:8]` goes to the high lane. The other lane keeps its value.
- R5: In byte mode (`wide` = 0), a selected write stores `wr_data[7:0]` into byte address {`addr`, `byte_a0`}. That is the low lane of word `addr` when `byte_a0` = 0, and the high lane when `byte_a0` = 1. The lane enables are ignored.
- R6: In byte mode, a read drives the addressed byte on `rd_data[7:0]` with `rd_drive` = 2'b01, whatever the lane enables are. The upper lane is never driven.
- R7: While `rd_n` = 1, `rd_drive` is 2'b00.
- R8: While `wr_n` = 0, `rd_drive` is 2'b00 even when `rd_n` = 0.
- R9: Every lane whose `rd_drive` bit is 0 reads as 8'h00 on `rd_data`.
- R10: While `rst_n` = 0, no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write capture clock |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| wide | input | 1 | 1 = 16-bit word organization, 0 = 8-bit byte organization |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| wr_n | input | 1 | Write enable, active low |
| rd_n | input | 1 | Output enable, active low |
| lane_lo_n | input | 1 | Low byte lane enable, active low (word mode) |
| lane_hi_n | input | 1 | High byte lane enable, active low (word mode) |
| addr | input | AW | Word address |
| byte_a0 | input | 1 | Least significant byte-address bit (byte mode) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, zero on undriven lanes |
| rd_drive | output | 2 | Per-lane output drive: bit 0 low lane, bit 1 high lane |

## Verification
The bench goes after lane isolation first. A partial word write that leaked into the other lane, or a byte write steered by the wrong address bit, would corrupt a neighbouring byte, and the corruption shows up on a later full-word read. The bench then checks the enable corners. A design that missed the all-lanes-off deselect, let `rd_n` drive during a write, or kept honouring lane enables in byte mode would drive a lane it should leave quiet, or fail to drive one it should. A write attempted during reset and a write attempted while deselected are both read back afterwards. A design that wrote anyway would return the stray data.

// File: rtl/swsram_pkg.sv
package swsram_pkg;

    localparam int LANES = 2;
    localparam int LANE_W = 8;

    typedef logic [LANE_W-1:0] lane_t;

    // decoded access for one cycle
    typedef struct packed {
        logic               sel;      // device selected
        logic               rd;       // read condition holds
        logic               wr;       // write condition holds
        logic [LANES-1:0]   wr_mask;  // lanes written at the next edge
        logic [LANES-1:0]   rd_mask;  // lanes driven on read
        logic               narrow;   // byte organization
        logic               pick;     // lane picked in byte mode
    } access_t;

endpackage

// File: rtl/swsram_decode.sv
module swsram_decode
    import swsram_pkg::*;
(
    input  logic                     rst_n,
    input  logic                     wide,
    input  logic                     cs1_n,
    input  logic                     cs2,
    input  logic                     wr_n,
    input  logic                     rd_n,
    input  logic                     lane_lo_n,
    input  logic                     lane_hi_n,
    input  logic                     byte_a0,
    input  logic [2*LANE_W-1:0]      wr_data,
    output access_t                  acc,
    output lane_t [LANES-1:0]        lane_wd
);

    logic lanes_off;
    logic chip_on;

    always_comb begin
        chip_on   = !cs1_n && cs2;
        lanes_off = wide && lane_lo_n && lane_hi_n;

        acc        = '0;
        acc.narrow = !wide;
        acc.pick   = byte_a0;
        acc.sel    = chip_on && !lanes_off;
        acc.rd     = acc.sel && wr_n && !rd_n;
        acc.wr     = acc.sel && !wr_n && rst_n;

        if (wide) begin
            acc.wr_mask = acc.wr ? {!lane_hi_n, !lane_lo_n} : 2'b00;
            acc.rd_mask = acc.rd ? {!lane_hi_n, !lane_lo_n} : 2'b00;
            lane_wd[0]  = wr_data[LANE_W-1:0];
            lane_wd[1]  = wr_data[2*LANE_W-1:LANE_W];
        end else begin
            acc.wr_mask = acc.wr ? {byte_a0, !byte_a0} : 2'b00;
            acc.rd_mask = {1'b0, acc.rd};
            lane_wd[0]  = wr_data[LANE_W-1:0];
            lane_wd[1]  = wr_data[LANE_W-1:0];
        end
    end

endmodule

// File: rtl/swsram_bank.sv
module swsram_bank
    import swsram_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  lane_t             wd,
    output lane_t             rd
);

    lane_t mem_q [WORDS];
    lane_t mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wd;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd = mem_q[addr];

endmodule

// File: rtl/swsram_steer.sv
module swsram_steer
    import swsram_pkg::*;
(
    input  access_t               acc,
    input  lane_t [LANES-1:0]     lane_rd,
    output logic [2*LANE_W-1:0]   rd_data,
    output logic [LANES-1:0]      rd_drive
);

    always_comb begin
        rd_data  = '0;
        rd_drive = acc.rd_mask;
        if (acc.narrow) begin
            if (acc.rd_mask[0]) begin
                rd_data[LANE_W-1:0] = acc.pick ? lane_rd[1] : lane_rd[0];
            end
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (acc.rd_mask[l]) begin
                    rd_data[l*LANE_W +: LANE_W] = lane_rd[l];
                end
            end
        end
    end

endmodule

// File: rtl/swsram_core.sv
module swsram_core
    import swsram_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int AW = $clog2(WORDS),
    localparam int DW = LANES * LANE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide,
    input  logic            cs1_n,
    input  logic            cs2,
    input  logic            wr_n,
    input  logic            rd_n,
    input  logic            lane_lo_n,
    input  logic            lane_hi_n,
    input  logic [AW-1:0]   addr,
    input  logic            byte_a0,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd_data,
    output logic [1:0]      rd_drive
);

    access_t           acc;
    lane_t [LANES-1:0] lane_wd;
    lane_t [LANES-1:0] lane_rd;

    swsram_decode u_decode (
        .rst_n     (rst_n),
        .wide      (wide),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .lane_lo_n (lane_lo_n),
        .lane_hi_n (lane_hi_n),
        .byte_a0   (byte_a0),
        .wr_data   (wr_data),
        .acc       (acc),
        .lane_wd   (lane_wd)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        swsram_bank #(.WORDS(WORDS)) u_bank (
            .clk  (clk),
            .we   (acc.wr_mask[g]),
            .addr (addr),
            .wd   (lane_wd[g]),
            .rd   (lane_rd[g])
        );
    end

    swsram_steer u_steer (
        .acc      (acc),
        .lane_rd  (lane_rd),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

endmodule

// File: rtl/swsram_core_chk.sv
module swsram_core_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wide,
    input logic          cs1_n,
    input logic          cs2,
    input logic          wr_n,
    input logic          rd_n,
    input logic          lane_lo_n,
    input logic          lane_hi_n,
    input logic [15:0]   rd_data,
    input logic [1:0]    rd_drive
);

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n || !cs2) |-> (rd_drive == 2'b00));                          // R1
    AST_NO_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && lane_lo_n && lane_hi_n) |-> (rd_drive == 2'b00));         // R2
    AST_WORD_LANE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !cs1_n && cs2 && wr_n && !rd_n)
            |-> (rd_drive == {!lane_hi_n, !lane_lo_n}));                   // R3
    AST_BYTE_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !cs1_n && cs2 && wr_n && !rd_n) |-> (rd_drive == 2'b01)); // R6
    AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (rd_drive == 2'b00));                                     // R7
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (rd_drive == 2'b00));                                    // R8
    AST_IDLE_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive[0] |-> (rd_data[7:0] == 8'h00));                         // R9
    AST_IDLE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive[1] |-> (rd_data[15:8] == 8'h00));                        // R9

endmodule

bind swsram_core swsram_core_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide      (wide),
    .cs1_n     (cs1_n),
    .cs2       (cs2),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .lane_lo_n (lane_lo_n),
    .lane_hi_n (lane_hi_n),
    .rd_data   (rd_data),
    .rd_drive  (rd_drive)
);

// File: tb/swsram_core_tb.sv
module swsram_core_tb;

    localparam int WORDS = 256;
    localparam int AW = $clog2(WORDS);

    logic          clk = 1'b0;
    logic          rst_n, wide, cs1_n, cs2, wr_n, rd_n, lane_lo_n, lane_hi_n, byte_a0;
    logic [AW-1:0] addr;
    logic [15:0]   wr_data;
    logic [15:0]   rd_data;
    logic [1:0]    rd_drive;

    logic [15:0]   model [WORDS];
    int            n_vec = 0;
    int            n_bad = 0;
    bit            done = 0;

    always #4 clk = ~clk;

    swsram_core #(.WORDS(WORDS)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (wide),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .lane_lo_n (lane_lo_n),
        .lane_hi_n (lane_hi_n),
        .addr      (addr),
        .byte_a0   (byte_a0),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rd_drive  (rd_drive)
    );

    function automatic logic [17:0] expect_out();
        logic sel, rd;
        logic [15:0] d;
        logic [1:0]  o;
        sel = !cs1_n && cs2 && !(wide && lane_lo_n && lane_hi_n);
        rd  = sel && wr_n && !rd_n;
        d = 16'h0000;
        o = 2'b00;
        if (wide) begin
            o = rd ? {!lane_hi_n, !lane_lo_n} : 2'b00;
            if (o[0]) d[7:0]  = model[addr][7:0];
            if (o[1]) d[15:8] = model[addr][15:8];
        end else begin
            o = {1'b0, rd};
            if (rd) d[7:0] = byte_a0 ? model[addr][15:8] : model[addr][7:0];
        end
        return {o, d};
    endfunction

    function automatic string auto_tag();
        if (!rst_n)                           return "R10";
        if (cs1_n || !cs2)                    return "R1";
        if (wide && lane_lo_n && lane_hi_n)   return "R2";
        if (!wr_n)                            return "R8";
        if (rd_n)                             return "R7";
        if (wide)                             return "R3";
        return "R6";
    endfunction

    task automatic step(input string tag, input logic rst, input logic wd_m,
                        input logic e1n, input logic e2, input logic wen,
                        input logic oen, input logic lon, input logic hin,
                        input logic [AW-1:0] a, input logic bs, input logic [15:0] wd);
        logic [17:0] ex;
        string t;
        @(negedge clk);
        rst_n = rst; wide = wd_m; cs1_n = e1n; cs2 = e2; wr_n = wen; rd_n = oen;
        lane_lo_n = lon; lane_hi_n = hin; addr = a; byte_a0 = bs; wr_data = wd;
        #1;
        ex = expect_out();
        t = (tag == "") ? auto_tag() : tag;
        n_vec++;
        if ({rd_drive, rd_data} !== ex) begin
            n_bad++;
            $display("FAIL %s: rd_drive=%b rd_data=%h expected rd_drive=%b rd_data=%h",
                     t, rd_drive, rd_data, ex[17:16], ex[15:0]);
        end
        // update the model for a write captured at the coming edge
        if (rst && !e1n && e2 && !wen && !(wd_m && lon && hin)) begin
            if (wd_m) begin
                if (!lon) model[a][7:0]  = wd[7:0];
                if (!hin) model[a][15:8] = wd[15:8];
            end else if (bs) begin
                model[a][15:8] = wd[7:0];
            end else begin
                model[a][7:0] = wd[7:0];
            end
        end
    endtask

    // word-mode full read of one address
    task automatic rd_word(input string tag, input logic [AW-1:0] a);
        step(tag, 1, 1, 0, 1, 1, 0, 0, 0, a, 0, 16'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        // reset state: deselected and idle, nothing driven (R1)
        step("R1", 0, 1, 1, 0, 1, 1, 1, 1, '0, 0, 16'h0);
        step("R10", 0, 1, 1, 0, 1, 1, 1, 1, '0, 0, 16'h0);
        // fill every word
        for (int i = 0; i < WORDS; i++)
            step("", 1, 1, 0, 1, 0, 0, 0, 0, AW'(i), 0, 16'(i * 16'h0107) ^ 16'h5a3c);

        // R10: write during reset must not land
        step("R10", 0, 1, 0, 1, 0, 1, 0, 0, 8'd5, 0, 16'hDEAD);
        rd_word("R10", 8'd5);
        // R1: write with each chip enable off
        step("R1", 1, 1, 1, 1, 0, 1, 0, 0, 8'd6, 0, 16'hBEEF);
        step("R1", 1, 1, 0, 0, 0, 1, 0, 0, 8'd6, 0, 16'hBEEF);
        rd_word("R1", 8'd6);
        // R2: word mode, both lanes off
        step("R2", 1, 1, 0, 1, 0, 1, 1, 1, 8'd9, 0, 16'hFACE);
        step("R2", 1, 1, 0, 1, 1, 0, 1, 1, 8'd9, 0, 16'h0);
        rd_word("R2", 8'd9);
        // R4: partial writes keep the other lane
        step("R4", 1, 1, 0, 1, 0, 1, 0, 0, 8'd3, 0, 16'h1234);
        step("R4", 1, 1, 0, 1, 0, 1, 1, 0, 8'd3, 0, 16'hAB99);
        rd_word("R4", 8'd3);
        step("R4", 1, 1, 0, 1, 0, 1, 0, 1, 8'd3, 0, 16'h77CD);
        rd_word("R4", 8'd3);
        // R9 / R3: single lane reads leave the other lane zero
        step("R9", 1, 1, 0, 1, 1, 0, 0, 1, 8'd3, 0, 16'h0);
        step("R9", 1, 1, 0, 1, 1, 0, 1, 0, 8'd3, 0, 16'h0);
        // R5: byte writes to both halves, lane enables set off (ignored)
        step("R5", 1, 0, 0, 1, 0, 0, 1, 1, 8'd7, 1, 16'hFF5C);
        step("R5", 1, 0, 0, 1, 0, 0, 1, 1, 8'd7, 0, 16'hEEA1);
        rd_word("R5", 8'd7);
        // R6: byte reads with lane enables off still drive the low lane
        step("R6", 1, 0, 0, 1, 1, 0, 1, 1, 8'd7, 1, 16'h0);
        step("R6", 1, 0, 0, 1, 1, 0, 1, 1, 8'd7, 0, 16'h0);
        // R7 and R8 corners
        step("R7", 1, 1, 0, 1, 1, 1, 0, 0, 8'd7, 0, 16'h0);
        step("R8", 1, 1, 0, 1, 0, 0, 0, 0, 8'd8, 0, 16'h4321);
        rd_word("R8", 8'd8);

        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic e1n, e2, wen, oen, lon, hin, wm, bs;
            e1n = ($urandom % 8) == 0;
            e2  = ($urandom % 8) != 0;
            wen = ($urandom % 3) == 0;
            oen = ($urandom % 5) == 0;
            lon = ($urandom % 3) == 0;
            hin = ($urandom % 3) == 0;
            wm  = $urandom % 2;
            bs  = $urandom % 2;
            step("", 1, wm, e1n, e2, wen, oen, lon, hin, AW'($urandom % WORDS), bs,
                 16'($urandom));
        end
        // final sweep of all words
        for (int i = 0; i < WORDS; i++) rd_word("R3", AW'(i));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule